// File: doc/BRIEF.md
# One-Time-Programmable Memory Burn Sequencer

This controller writes the full contents of a one-time-programmable byte memory. The contents come from a source that it reads one address at a time. After a start request it turns on the elevated core and programming supplies. It waits for them to settle, then runs three passes over the address range.

- **Blind pass.** Every byte receives one timed program strobe and is not read back.
- **Verify pass.** Each byte is read back. A byte that does not match receives another strobe followed by another read, for a bounded number of retries.
- **Read-back pass.** The supplies return to nominal. Every byte is read once more and compared with the source.

The result is a single done pulse with a pass flag. On failure the block also reports the failing address and a code for the pass in which it failed. All timing is given as clock-cycle parameters: strobe width, setup, hold, supply settling and read access. The last address is a parameter, so a bench can work with a small memory.

Top module: `prom_burn_seq`

## Requirements
- R1: After reset the block is idle. Chip enable, output enable and program strobe are high (all three active low). Both supply enables, done, busy and the source request are low.
- R2: A start request raises both supply enables together. No program strobe falls sooner than SUPPLY_CYC cycles after they rise. Programming begins at address 0.
- R3: Each program strobe is low for exactly PULSE_CYC cycles. Address, write data and chip enable are stable for at least SETUP_CYC cycles before the strobe falls. They stay stable for at least HOLD_CYC cycles after it rises.
- R4: In the blind pass, addresses 0 to LAST_ADDR each receive exactly one strobe, in ascending order, and no read is made.
- R5: In the verify pass, each address is read with output enable low for READ_CYC cycles. The data is compared in the last of those cycles. On a mismatch the block applies one more strobe and reads again, up to MAX_RETRY extra strobes per address. A byte that needs n strobes in total, with n ≤ MAX_RETRY+1, therefore receives exactly n strobes.
- R6: If a byte still mismatches after MAX_RETRY extra strobes, the block stops. It reports failure with that address and phase code 0 (0 = verify pass, 1 = read-back pass). No higher address receives a second strobe.
- R7: After the verify pass, both supply enables fall. The first read-back read comes at least SUPPLY_CYC cycles later. Every address is then read in ascending order with no strobe. The first mismatch ends the run as a failure with that address and phase code 1. If every byte matches, the run passes.
- R8: done is high for exactly one cycle per run. The pass flag, failing address and phase code stay unchanged after it until the next start.
- R9: A start request while the block is busy has no effect.
- R10: The source request stays high with a stable address until the source acknowledges it. The byte is taken in the acknowledge cycle.
- R11: The program strobe is low only while both supply enables are high, chip enable is low and output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Result of the last run, 1 = all bytes good |
| fail_addr_o | output | ADDR_W | Address that failed in the last run |
| fail_phase_o | output | 1 | 0 = failed in verify, 1 = failed in read-back |
| src_req_o | output | 1 | Source byte request |
| src_addr_o | output | ADDR_W | Address of the requested source byte |
| src_ack_i | input | 1 | Source acknowledge, one cycle |
| src_data_i | input | DATA_W | Source byte, valid with the acknowledge |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_dout_o | output | DATA_W | Data driven to the memory for programming |
| mem_din_i | input | DATA_W | Data read from the memory |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_pgm_n_o | output | 1 | Program strobe, active low |
| vcc_hi_o | output | 1 | Selects the elevated core supply |
| vpp_hi_o | output | 1 | Selects the elevated programming supply |

## Verification
The assertions assume the following about the environment:
- The source acknowledge arrives only while a request is pending and lasts one cycle.
- The memory data input is meaningful only while both enables are low.

The bench's source model answers after a fixed delay and drops the acknowledge on the next cycle. Its memory model drives read data only while both enables are low. The memory model counts strobes per byte and reports a byte as programmed only after a per-address number of strobes. It can also corrupt one byte during reads at nominal supply. Together these let the sweeps reach the retry limit, the verify failure and the read-back failure without leaving the handshake rules the assertions rely on.

// File: rtl/prom_seq_pkg.sv
package prom_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_READ
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_BLIND,
        PH_VERIFY,
        PH_FINAL
    } seq_phase_e;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R3
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/retry_ctr.sv
module retry_ctr #(
    parameter int MAX = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic max_o
);
    localparam int CW = $clog2(MAX + 1) + 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign max_o = (cnt_q == CW'(MAX));

    // R5
    retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX));
endmodule

// File: rtl/prom_burn_seq.sv
module prom_burn_seq
    import prom_seq_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 8,
    parameter int LAST_ADDR  = 262143,
    parameter int PULSE_CYC  = 5000,
    parameter int SETUP_CYC  = 2,
    parameter int HOLD_CYC   = 2,
    parameter int SUPPLY_CYC = 50,
    parameter int READ_CYC   = 2,
    parameter int MAX_RETRY  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic              fail_phase_o,
    output logic              src_req_o,
    output logic [ADDR_W-1:0] src_addr_o,
    input  logic              src_ack_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dout_o,
    input  logic [DATA_W-1:0] mem_din_i,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    output logic              mem_pgm_n_o,
    output logic              vcc_hi_o,
    output logic              vpp_hi_o
);
    localparam int TMAX_A = (PULSE_CYC > SUPPLY_CYC) ? PULSE_CYC : SUPPLY_CYC;
    localparam int TMAX_B = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int TMAX_C = (TMAX_B > READ_CYC) ? TMAX_B : READ_CYC;
    localparam int TMAX   = (TMAX_A > TMAX_C) ? TMAX_A : TMAX_C;
    localparam int TW     = $clog2(TMAX + 1);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);

    typedef struct packed {
        seq_state_e        state;
        seq_phase_e        phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              sup;
        logic              done;
        logic              pass;
        logic [ADDR_W-1:0] fail_addr;
        logic              fail_phase;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          rtr_clr, rtr_inc, rtr_max;
    logic          req_d;
    logic          rd_match;

    seq_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    retry_ctr #(.MAX(MAX_RETRY)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (rtr_clr),
        .inc_i (rtr_inc),
        .max_o (rtr_max)
    );

    assign rd_match = (mem_din_i == r_q.data);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        req_d    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        rtr_clr  = 1'b0;
        rtr_inc  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state      = ST_SETTLE;
                    r_d.phase      = PH_BLIND;
                    r_d.addr       = '0;
                    r_d.sup        = 1'b1;
                    r_d.pass       = 1'b0;
                    r_d.fail_addr  = '0;
                    r_d.fail_phase = 1'b0;
                    rtr_clr        = 1'b1;
                    tmr_load       = 1'b1;
                    tmr_val        = TW'(SUPPLY_CYC - 1);
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) r_d.state = ST_FETCH;
            end
            ST_FETCH: begin
                req_d = 1'b1;
                if (src_ack_i) begin
                    r_d.data = src_data_i;
                    tmr_load = 1'b1;
                    if (r_q.phase == PH_BLIND) begin
                        r_d.state = ST_SETUP;
                        tmr_val   = TW'(SETUP_CYC - 1);
                    end else begin
                        r_d.state = ST_READ;
                        tmr_val   = TW'(READ_CYC - 1);
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    r_d.state = ST_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(PULSE_CYC - 1);
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    r_d.state = ST_HOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(HOLD_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    if (r_q.phase == PH_BLIND) begin
                        r_d.state = ST_FETCH;
                        if (r_q.addr == LAST) begin
                            r_d.phase = PH_VERIFY;
                            r_d.addr  = '0;
                        end else begin
                            r_d.addr  = r_q.addr + 1'b1;
                        end
                    end else begin
                        r_d.state = ST_READ;
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(READ_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (tmr_zero) begin
                    if (rd_match) begin
                        rtr_clr = 1'b1;
                        if (r_q.addr != LAST) begin
                            r_d.addr  = r_q.addr + 1'b1;
                            r_d.state = ST_FETCH;
                        end else if (r_q.phase == PH_VERIFY) begin
                            r_d.addr  = '0;
                            r_d.phase = PH_FINAL;
                            r_d.sup   = 1'b0;
                            r_d.state = ST_SETTLE;
                            tmr_load  = 1'b1;
                            tmr_val   = TW'(SUPPLY_CYC - 1);
                        end else begin
                            r_d.pass  = 1'b1;
                            r_d.done  = 1'b1;
                            r_d.state = ST_IDLE;
                        end
                    end else if (r_q.phase == PH_VERIFY && !rtr_max) begin
                        rtr_inc   = 1'b1;
                        r_d.state = ST_SETUP;
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(SETUP_CYC - 1);
                    end else begin
                        r_d.fail_addr  = r_q.addr;
                        r_d.fail_phase = (r_q.phase == PH_FINAL);
                        r_d.sup        = 1'b0;
                        r_d.done       = 1'b1;
                        r_d.state      = ST_IDLE;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.phase <= PH_BLIND;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.state != ST_IDLE);
    assign done_o       = r_q.done;
    assign pass_o       = r_q.pass;
    assign fail_addr_o  = r_q.fail_addr;
    assign fail_phase_o = r_q.fail_phase;
    assign src_req_o    = req_d;
    assign src_addr_o   = r_q.addr;
    assign mem_addr_o   = r_q.addr;
    assign mem_dout_o   = r_q.data;
    assign mem_ce_n_o   = !(r_q.state inside {ST_SETUP, ST_PULSE, ST_HOLD, ST_READ});
    assign mem_oe_n_o   = (r_q.state != ST_READ);
    assign mem_pgm_n_o  = (r_q.state != ST_PULSE);
    assign vcc_hi_o     = r_q.sup;
    assign vpp_hi_o     = r_q.sup;

    // R11
    strobe_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_pgm_n_o |-> (vpp_hi_o && vcc_hi_o && !mem_ce_n_o && mem_oe_n_o));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req_o && !src_ack_i) |=> (src_req_o && $stable(src_addr_o)));

    // R7
    final_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_FINAL && busy_o) |-> (mem_pgm_n_o && !vpp_hi_o));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(fail_addr_o) && $stable(fail_phase_o)));
endmodule

// File: tb/prom_burn_seq_tb.sv
module prom_burn_seq_tb;
    localparam int AW     = 4;
    localparam int DW     = 8;
    localparam int LAST   = 15;
    localparam int DEPTH  = LAST + 1;
    localparam int PULSE  = 20;
    localparam int SETUP  = 3;
    localparam int HOLD   = 2;
    localparam int SUPPLY = 10;
    localparam int READ   = 2;
    localparam int RETRY  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, pass, fail_phase, src_req, src_ack = 1'b0;
    logic [AW-1:0] fail_addr, src_addr, mem_addr;
    logic [DW-1:0] src_data = '0, mem_dout, mem_din;
    logic ce_n, oe_n, pgm_n, vcc_hi, vpp_hi;

    always #10 clk = ~clk;

    prom_burn_seq #(
        .ADDR_W(AW), .DATA_W(DW), .LAST_ADDR(LAST), .PULSE_CYC(PULSE),
        .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .SUPPLY_CYC(SUPPLY),
        .READ_CYC(READ), .MAX_RETRY(RETRY)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
        .pass_o(pass), .fail_addr_o(fail_addr), .fail_phase_o(fail_phase),
        .src_req_o(src_req), .src_addr_o(src_addr), .src_ack_i(src_ack),
        .src_data_i(src_data), .mem_addr_o(mem_addr), .mem_dout_o(mem_dout),
        .mem_din_i(mem_din), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n),
        .mem_pgm_n_o(pgm_n), .vcc_hi_o(vcc_hi), .vpp_hi_o(vpp_hi)
    );

    int n_tests = 0;
    int n_fail  = 0;

    int need   [DEPTH];
    int pulses [DEPTH];
    logic [DW-1:0] wr [DEPTH];
    int bad_final = -1;

    int err_width, err_setup, err_hold, err_supply, err_order, err_strobe, err_settle;
    int final_reads, reads_seen, blind_idx, done_cnt;

    function automatic logic [DW-1:0] src_of(int a);
        return DW'((a * 37 + 5) & 255);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // memory model: byte reads back programmed only after need[a] strobes
    always_comb begin
        logic [DW-1:0] v;
        v = 8'hFF;
        if (pulses[mem_addr] >= need[mem_addr]) v = wr[mem_addr];
        if (!vpp_hi && int'(mem_addr) == bad_final) v = v ^ 8'h01;
        mem_din = (!ce_n && !oe_n) ? v : '0;
    end

    // source model: acknowledge two cycles after a request
    int src_dly = 0;
    always @(negedge clk) begin
        if (src_ack) begin
            src_ack = 1'b0;
        end else if (src_req && rst_n) begin
            if (src_dly == 2) begin
                src_ack  = 1'b1;
                src_data = src_of(int'(src_addr));
                src_dly  = 0;
            end else begin
                src_dly++;
            end
        end
    end

    // protocol monitor
    logic p_pgm = 1'b1, p_oe = 1'b1, p_sup = 1'b0, p_ce = 1'b1;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dout = '0;
    int stab = 0, since = 0, lowlen = 0, sup_cnt = 0, down_cnt = 0;
    bit hold_pend = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            since++;
            if ({mem_addr, mem_dout, ce_n} != {p_addr, p_dout, p_ce}) begin
                stab = 0;
                if (hold_pend && since < HOLD) err_hold++;
                hold_pend = 0;
            end else begin
                stab++;
            end
            if (vpp_hi && !p_sup) sup_cnt = 0; else sup_cnt++;
            if (!vpp_hi && p_sup) down_cnt = 0; else down_cnt++;
            if (!pgm_n && (!vpp_hi || !vcc_hi || ce_n || !oe_n)) err_strobe++;
            if (!pgm_n && p_pgm) begin
                pulses[mem_addr]++;
                wr[mem_addr] = mem_dout;
                if (stab < SETUP) err_setup++;
                if (sup_cnt < SUPPLY) err_supply++;
                if (reads_seen == 0) begin
                    if (int'(mem_addr) != blind_idx) err_order++;
                    blind_idx++;
                end
            end
            if (!pgm_n) lowlen++;
            if (pgm_n && !p_pgm) begin
                if (lowlen != PULSE) err_width++;
                lowlen = 0;
                hold_pend = 1;
                since = 0;
            end
            if (!oe_n && p_oe) begin
                reads_seen++;
                if (!vpp_hi) begin
                    final_reads++;
                    if (down_cnt < SUPPLY) err_settle++;
                end
            end
            if (done) done_cnt++;
            p_pgm = pgm_n; p_oe = oe_n; p_sup = vpp_hi; p_ce = ce_n;
            p_addr = mem_addr; p_dout = mem_dout;
        end
    end

    task automatic clear_model();
        for (int a = 0; a < DEPTH; a++) begin
            pulses[a] = 0;
            wr[a] = 8'hFF;
        end
        err_width = 0; err_setup = 0; err_hold = 0; err_supply = 0;
        err_order = 0; err_strobe = 0; err_settle = 0;
        final_reads = 0; reads_seen = 0; blind_idx = 0; done_cnt = 0;
    endtask

    task automatic run_case(input string name, input bit mid_start, input bit exp_pass,
                            input int exp_addr, input int exp_phase);
        int cyc;
        int exp_reads;
        logic r_pass, r_phase;
        logic [AW-1:0] r_addr;
        clear_model();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (done_cnt == 0 && cyc < 40000) begin
            @(negedge clk);
            cyc++;
            if (mid_start && cyc == 300) start = 1'b1;
            if (mid_start && cyc == 301) start = 1'b0;
        end
        check(cyc < 40000, {name, " watchdog R8"}, cyc, 40000);
        r_pass = pass; r_addr = fail_addr; r_phase = fail_phase;
        check(r_pass == exp_pass, {name, " R7 pass flag"}, int'(r_pass), int'(exp_pass));
        if (!exp_pass) begin
            check(int'(r_addr) == exp_addr, {name, " R6/R7 fail address"}, int'(r_addr), exp_addr);
            check(int'(r_phase) == exp_phase, {name, " R6/R7 fail phase"}, int'(r_phase), exp_phase);
        end
        repeat (8) @(negedge clk);
        check(done_cnt == 1, {name, " R8 R9 single done"}, done_cnt, 1);
        check(pass == r_pass && fail_addr == r_addr && fail_phase == r_phase,
              {name, " R8 result held"}, int'({pass, fail_addr, fail_phase}),
              int'({r_pass, r_addr, r_phase}));
        check(!busy, {name, " R9 idle after done"}, int'(busy), 0);
        for (int a = 0; a < DEPTH; a++) begin
            int exp_p;
            if (exp_pass || exp_phase == 1 || a < exp_addr) exp_p = need[a];
            else if (a == exp_addr) exp_p = RETRY + 1;
            else exp_p = 1;
            check(pulses[a] == exp_p, {name, " R4/R5/R6 strobe count"}, pulses[a], exp_p);
        end
        exp_reads = exp_pass ? DEPTH : (exp_phase == 1 ? exp_addr + 1 : 0);
        check(final_reads == exp_reads, {name, " R7 read-back count"}, final_reads, exp_reads);
        check(err_width == 0, {name, " R3 strobe width"}, err_width, 0);
        check(err_setup == 0, {name, " R3 setup"}, err_setup, 0);
        check(err_hold == 0, {name, " R3 hold"}, err_hold, 0);
        check(err_supply == 0, {name, " R2 supply settle"}, err_supply, 0);
        check(err_order == 0 && blind_idx == DEPTH, {name, " R4 R2 blind order"}, blind_idx, DEPTH);
        check(err_strobe == 0, {name, " R11 strobe conditions"}, err_strobe, 0);
        check(err_settle == 0, {name, " R7 nominal settle"}, err_settle, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ce_n && oe_n && pgm_n, "R1 enables idle", int'({ce_n, oe_n, pgm_n}), 7);
        check(!vcc_hi && !vpp_hi, "R1 supplies low", int'({vcc_hi, vpp_hi}), 0);
        check(!done && !busy && !src_req, "R1 status low", int'({done, busy, src_req}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // varied strobe needs, one at the retry limit, plus a start while busy (R9)
        for (int a = 0; a < DEPTH; a++) need[a] = (a % 4) + 1;
        need[5] = RETRY + 1;
        bad_final = -1;
        run_case("pass_mix", 1'b1, 1'b1, 0, 0);

        // verify failure in the middle (R6)
        for (int a = 0; a < DEPTH; a++) need[a] = 1;
        need[6] = RETRY + 2;
        run_case("verify_fail_mid", 1'b0, 1'b0, 6, 0);

        // verify failure at the last address (R6)
        for (int a = 0; a < DEPTH; a++) need[a] = 1;
        need[LAST] = RETRY + 2;
        run_case("verify_fail_last", 1'b0, 1'b0, LAST, 0);

        // read-back failure (R7)
        for (int a = 0; a < DEPTH; a++) need[a] = (a % 3) + 1;
        bad_final = 11;
        run_case("final_fail", 1'b0, 1'b0, 11, 1);

        // clean run after a failure (R8 result replaced on new start)
        for (int a = 0; a < DEPTH; a++) need[a] = 1;
        bad_final = -1;
        run_case("pass_clean", 1'b0, 1'b1, 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 190000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule